// File: doc/BRIEF.md
# Serial Bus Memory Slave Engine

This block is the bus-facing front end of a small byte-wide memory. It watches an open-drain two-wire bus (a clock line and a data line) from a fast system clock. It detects bus start and stop conditions and decodes the slave-address byte against a fixed device-type prefix and three strap pins. After that it runs either a write transfer or a read transfer.

In a write transfer, the first byte after the address loads a 7-bit word pointer. Each byte after that is handed to the memory on a one-cycle write strobe, and the pointer then advances. In a read transfer, the byte at the pointer is shifted out MSB first. The block keeps sending bytes for as long as the master acknowledges them. While the memory reports that its internal write cycle is running, the block does not answer its own address. The memory array, page buffer and programming timer sit behind a plain byte port and are not part of this block.

Top module: `serial_mem_slave`

## Requirements
- R1: A START (data line falls while the clock line is high) begins slave-address reception. A STOP (data line rises while the clock line is high) returns the block to idle with the data line released.
- R2: Out of reset, and after a STOP, the block drives nothing and writes nothing until a START is seen, whatever the clock and data lines do.
- R3: Bit 0 of the address byte is the direction, where 1 means read and 0 means write. Bits 7..4 must equal 1010 and bits 3..1 must equal the strap pins. Only a match is acknowledged, by holding the data line low through the ninth clock. A mismatch leaves the line released until the next START.
- R4: While the write-busy input is high, a matching address is not acknowledged.
- R5: In a write transfer, every received byte is acknowledged. Bits 6..0 of the first byte load the pointer, and bit 7 is ignored. Each later byte produces one write strobe at the current pointer, and the pointer then increments.
- R6: A read transfer sends the byte at the pointer MSB first, one bit per clock-low phase. The pointer increments for each byte sent. While the master acknowledges, the following byte goes out next.
- R7: The pointer wraps from 127 to 0 after both writes and reads.
- R8: A master not-acknowledge after a read byte ends the transfer. The block then leaves the data line released for all further clocks until the next START or STOP.
- R9: A START that arrives in the middle of a transfer, including part-way through a data byte, discards that byte without a write and restarts address reception. The pointer is kept, so a write of the word address followed by a repeated START and a read returns the data at that address.
- R10: The data-line drive enable changes only while the synchronized clock line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_drive_low_o | output | 1 | 1 pulls the data line low, 0 releases it |
| strap_i | input | 3 | Board-selected device address bits |
| wr_busy_i | input | 1 | Memory internal write cycle in progress |
| mem_rdata_i | input | 8 | Byte at mem_addr_o, combinational read |
| mem_addr_o | output | 7 | Byte address for read and write |
| mem_wdata_o | output | 8 | Write data, valid with mem_we_o |
| mem_we_o | output | 1 | One-cycle write strobe |

## Verification
On one clock falling edge the block has two jobs. It must release the acknowledge of a read address, and it must start driving the first data bit, which comes from a byte fetched in that same cycle. The bench sets this up with a random read whose first byte has a 1 in its MSB, so a late release would show up as a wrong MSB. It then compares every bit it reads against its own copy of the memory contents. In the same way, the write strobe and the pointer step fall in one cycle. This is judged by writing across address 127 and checking that the bytes land at 127 and 0.

// File: rtl/sms_pkg.sv
package sms_pkg;

  localparam logic [3:0] DEV_TYPE = 4'b1010;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_WADDR,
    ST_WDATA,
    ST_ACK_WAIT,
    ST_ACK_HOLD,
    ST_RDATA,
    ST_RD_ACK,
    ST_WAIT_STOP
  } sms_state_e;

endpackage

// File: rtl/sms_rst_sync.sv
module sms_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= 2'b00;
    else        chain_q <= {chain_q[0], 1'b1};
  end

  assign rst_sync_n = chain_q[1];

endmodule

// File: rtl/sms_line_sync.sv
module sms_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES-1:0] scl_pipe_q, sda_pipe_q;
  logic              scl_prev_q, sda_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe_q <= '1;
      sda_pipe_q <= '1;
      scl_prev_q <= 1'b1;
      sda_prev_q <= 1'b1;
    end else begin
      scl_pipe_q <= {scl_pipe_q[STAGES-2:0], scl_i};
      sda_pipe_q <= {sda_pipe_q[STAGES-2:0], sda_i};
      scl_prev_q <= scl_pipe_q[STAGES-1];
      sda_prev_q <= sda_pipe_q[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe_q[STAGES-1];
  assign sda_s     = sda_pipe_q[STAGES-1];
  assign scl_rise  = scl_s & ~scl_prev_q;
  assign scl_fall  = ~scl_s & scl_prev_q;
  assign start_det = scl_s & scl_prev_q & sda_prev_q & ~sda_s;
  assign stop_det  = scl_s & scl_prev_q & ~sda_prev_q & sda_s;

endmodule

// File: rtl/sms_ctrl.sv
module sms_ctrl
  import sms_pkg::*;
#(
  parameter int AW = 7,
  parameter int DW = 8,
  parameter int SW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_s,
  input  logic          sda_s,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic [SW-1:0] strap,
  input  logic          busy,
  input  logic [DW-1:0] mem_rdata,
  output logic          sda_oe,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we
);

  localparam int             CW   = $clog2(DW);
  localparam logic [CW-1:0]  LAST = CW'(DW - 1);

  sms_state_e    state_q, state_d, ret_q, ret_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [DW-1:0] shreg_q, shreg_d;
  logic [AW-1:0] ptr_q, ptr_d;
  logic          oe_q, oe_d, we_q, we_d, mack_q, mack_d;
  logic [DW-1:0] byte_in;
  logic          byte_end;

  assign byte_in  = {shreg_q[DW-2:0], sda_s};
  assign byte_end = scl_rise && (cnt_q == LAST);

  always_comb begin
    state_d = state_q;
    ret_d   = ret_q;
    cnt_d   = cnt_q;
    shreg_d = shreg_q;
    ptr_d   = ptr_q;
    oe_d    = oe_q;
    mack_d  = mack_q;
    we_d    = 1'b0;
    if (we_q) ptr_d = ptr_q + 1'b1;
    if (stop_det) begin
      state_d = ST_IDLE;
      oe_d    = 1'b0;
    end else if (start_det) begin
      state_d = ST_DEV;
      cnt_d   = '0;
      oe_d    = 1'b0;
    end else begin
      case (state_q)
        ST_DEV, ST_WADDR, ST_WDATA: begin
          if (scl_rise) begin
            shreg_d = byte_in;
            cnt_d   = cnt_q + 1'b1;
          end
          if (byte_end) begin
            state_d = ST_ACK_WAIT;
            if (state_q == ST_DEV) begin
              ret_d = byte_in[0] ? ST_RDATA : ST_WADDR;
              if ((byte_in[DW-1:1] != {DEV_TYPE, strap}) || busy) state_d = ST_IDLE;
            end else if (state_q == ST_WADDR) begin
              ptr_d = byte_in[AW-1:0];
              ret_d = ST_WDATA;
            end else begin
              we_d  = 1'b1;
              ret_d = ST_WDATA;
            end
          end
        end
        ST_ACK_WAIT: begin
          if (scl_fall) begin
            oe_d    = 1'b1;
            state_d = ST_ACK_HOLD;
          end
        end
        ST_ACK_HOLD: begin
          if (scl_fall) begin
            oe_d    = 1'b0;
            cnt_d   = '0;
            state_d = ret_q;
            if (ret_q == ST_RDATA) begin
              shreg_d = mem_rdata;
              oe_d    = ~mem_rdata[DW-1];
              ptr_d   = ptr_q + 1'b1;
            end
          end
        end
        ST_RDATA: begin
          if (scl_fall) begin
            if (cnt_q == LAST) begin
              oe_d    = 1'b0;
              state_d = ST_RD_ACK;
            end else begin
              cnt_d   = cnt_q + 1'b1;
              shreg_d = {shreg_q[DW-2:0], 1'b0};
              oe_d    = ~shreg_q[DW-2];
            end
          end
        end
        ST_RD_ACK: begin
          if (scl_rise) mack_d = ~sda_s;
          if (scl_fall) begin
            if (mack_q) begin
              state_d = ST_RDATA;
              cnt_d   = '0;
              shreg_d = mem_rdata;
              oe_d    = ~mem_rdata[DW-1];
              ptr_d   = ptr_q + 1'b1;
            end else begin
              state_d = ST_WAIT_STOP;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ret_q   <= ST_WADDR;
      cnt_q   <= '0;
      shreg_q <= '0;
      ptr_q   <= '0;
      oe_q    <= 1'b0;
      we_q    <= 1'b0;
      mack_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      ret_q   <= ret_d;
      cnt_q   <= cnt_d;
      shreg_q <= shreg_d;
      ptr_q   <= ptr_d;
      oe_q    <= oe_d;
      we_q    <= we_d;
      mack_q  <= mack_d;
    end
  end

  assign sda_oe    = oe_q;
  assign mem_addr  = ptr_q;
  assign mem_wdata = shreg_q;
  assign mem_we    = we_q;

  AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (state_q == ST_IDLE && !oe_q)); // R1
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> (!oe_q && !we_q)); // R2
  AST_BUSY_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DEV && byte_end && busy) |=> (state_q == ST_IDLE && !oe_q)); // R4
  AST_WE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    we_q |=> !we_q); // R5
  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    we_q |=> (ptr_q == AW'($past(ptr_q) + 1'b1))); // R7
  AST_NACK_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT_STOP) |-> !oe_q); // R8
  AST_START_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (state_q == ST_DEV && cnt_q == '0 && !we_q)); // R9
  AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(oe_q) |-> !scl_s); // R10

endmodule

// File: rtl/serial_mem_slave.sv
module serial_mem_slave #(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 8,
  parameter int STRAP_W     = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_drive_low_o,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic               wr_busy_i,
  input  logic [DATA_W-1:0]  mem_rdata_i,
  output logic [ADDR_W-1:0]  mem_addr_o,
  output logic [DATA_W-1:0]  mem_wdata_o,
  output logic               mem_we_o
);

  logic rst_core_n;
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  sms_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  sms_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  sms_ctrl #(.AW(ADDR_W), .DW(DATA_W), .SW(STRAP_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .strap     (strap_i),
    .busy      (wr_busy_i),
    .mem_rdata (mem_rdata_i),
    .sda_oe    (sda_drive_low_o),
    .mem_addr  (mem_addr_o),
    .mem_wdata (mem_wdata_o),
    .mem_we    (mem_we_o)
  );

endmodule

// File: tb/serial_mem_slave_tb.sv
module serial_mem_slave_tb;

  localparam int Q = 10;

  logic       clk, rst_n, scl_m, sda_m, wr_busy;
  logic [2:0] strap;
  logic       sda_oe, mem_we, sda_line;
  logic [6:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;
  logic [7:0] tb_mem [128];
  logic [7:0] exp_mem [128];
  int         n_chk, n_bad, oe_cnt, we_cnt, viol_cnt;
  logic       prev_oe, done;

  assign sda_line  = sda_m & ~sda_oe;
  assign mem_rdata = tb_mem[mem_addr];

  serial_mem_slave u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_drive_low_o(sda_oe), .strap_i(strap), .wr_busy_i(wr_busy),
    .mem_rdata_i(mem_rdata), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_we_o(mem_we)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [7:0] init_val(int i);
    return 8'(i * 37 + 11);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 128; i++) tb_mem[i] <= init_val(i);
      oe_cnt <= 0; we_cnt <= 0; viol_cnt <= 0; prev_oe <= 1'b0;
    end else begin
      if (mem_we) tb_mem[mem_addr] <= mem_wdata;
      if (sda_oe) oe_cnt <= oe_cnt + 1;
      if (mem_we) we_cnt <= we_cnt + 1;
      if (sda_oe != prev_oe && scl_m) viol_cnt <= viol_cnt + 1;
      prev_oe <= sda_oe;
    end
  end

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq(); repeat (Q) @(negedge clk); endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq();
    scl_m = 1'b0; repeat (2) @(negedge clk);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic clk_bit(input logic v, output logic seen);
    sda_m = v; wq(); scl_m = 1'b1;
    repeat (Q/2) @(negedge clk); seen = sda_line;
    repeat (Q/2) @(negedge clk); scl_m = 1'b0; repeat (2) @(negedge clk);
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic rd_byte(input logic mack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin clk_bit(1'b1, s); b[i] = s; end
    clk_bit(~mack, s);
    sda_m = 1'b1;
  endtask

  initial begin
    done = 1'b0;
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic ack;
    logic [7:0] b;
    int oe0, we0;
    n_chk = 0; n_bad = 0;
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1; wr_busy = 1'b0; strap = 3'b101;
    for (int i = 0; i < 128; i++) exp_mem[i] = init_val(i);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R2 reset drive", int'(sda_oe), 0);
    chk("R2 reset strobe", int'(mem_we), 0);

    // R2: bus traffic without START
    oe0 = oe_cnt; we0 = we_cnt;
    scl_m = 1'b0; repeat (2) @(negedge clk);
    wr_byte({4'b1010, strap, 1'b0}, ack);
    wr_byte(8'h12, ack);
    chk("R2 no START drive", oe_cnt - oe0, 0);
    chk("R2 no START write", we_cnt - we0, 0);
    bus_stop();

    // R3: sweep all upper seven bits of the address byte
    for (int a = 0; a < 128; a++) begin
      bus_start();
      wr_byte({7'(a), 1'b0}, ack);
      chk("R3 address sweep", int'(ack), int'(a == {4'b1010, 3'b101}));
      bus_stop();
    end
    for (int s = 0; s < 8; s++) begin
      strap = 3'(s);
      bus_start(); wr_byte({4'b1010, 3'(s), 1'b0}, ack); bus_stop();
      chk("R3 strap match", int'(ack), 1);
      bus_start(); wr_byte({4'b1010, 3'(s ^ 1), 1'b0}, ack); bus_stop();
      chk("R3 strap mismatch", int'(ack), 0);
    end
    strap = 3'b011;

    // R4: busy
    wr_busy = 1'b1; oe0 = oe_cnt;
    bus_start(); wr_byte({4'b1010, strap, 1'b0}, ack); bus_stop();
    chk("R4 busy no ack", int'(ack), 0);
    chk("R4 busy no drive", oe_cnt - oe0, 0);
    wr_busy = 1'b0;

    // R5: write burst, bit 7 of word address ignored
    we0 = we_cnt;
    bus_start(); wr_byte({4'b1010, strap, 1'b0}, ack);
    chk("R3 ack write", int'(ack), 1);
    wr_byte(8'h85, ack); chk("R5 ack word addr", int'(ack), 1);
    wr_byte(8'hA5, ack); chk("R5 ack data0", int'(ack), 1);
    wr_byte(8'h3C, ack); chk("R5 ack data1", int'(ack), 1);
    wr_byte(8'hF0, ack); chk("R5 ack data2", int'(ack), 1);
    bus_stop();
    exp_mem[5] = 8'hA5; exp_mem[6] = 8'h3C; exp_mem[7] = 8'hF0;
    chk("R5 strobes", we_cnt - we0, 3);
    for (int i = 5; i < 8; i++) chk("R5 stored", int'(tb_mem[i]), int'(exp_mem[i]));

    // R7: write wrap
    bus_start(); wr_byte({4'b1010, strap, 1'b0}, ack);
    wr_byte(8'h7F, ack); wr_byte(8'h5A, ack); wr_byte(8'hC3, ack);
    bus_stop();
    exp_mem[127] = 8'h5A; exp_mem[0] = 8'hC3;
    chk("R7 write wrap 127", int'(tb_mem[127]), int'(exp_mem[127]));
    chk("R7 write wrap 0", int'(tb_mem[0]), int'(exp_mem[0]));

    // R9/R6: random read via repeated START
    bus_start(); wr_byte({4'b1010, strap, 1'b0}, ack); wr_byte(8'h05, ack);
    bus_start(); wr_byte({4'b1010, strap, 1'b1}, ack);
    chk("R9 read addr ack", int'(ack), 1);
    rd_byte(1'b1, b); chk("R6 read byte0", int'(b), int'(exp_mem[5]));
    rd_byte(1'b1, b); chk("R6 read byte1", int'(b), int'(exp_mem[6]));
    rd_byte(1'b0, b); chk("R6 read byte2", int'(b), int'(exp_mem[7]));
    // R8: clocks after NACK see a released line
    oe0 = oe_cnt;
    rd_byte(1'b0, b); chk("R8 released after nack", int'(b), 8'hFF);
    chk("R8 no drive after nack", oe_cnt - oe0, 0);
    bus_stop();

    // R6: current-address read continues at pointer 8
    bus_start(); wr_byte({4'b1010, strap, 1'b1}, ack);
    rd_byte(1'b0, b); bus_stop();
    chk("R6 current read", int'(b), int'(exp_mem[8]));

    // R7: read wrap
    bus_start(); wr_byte({4'b1010, strap, 1'b0}, ack); wr_byte(8'h7F, ack);
    bus_start(); wr_byte({4'b1010, strap, 1'b1}, ack);
    rd_byte(1'b1, b); chk("R7 read 127", int'(b), int'(exp_mem[127]));
    rd_byte(1'b0, b); chk("R7 read wrap 0", int'(b), int'(exp_mem[0]));
    bus_stop();

    // R1: STOP mid-write, later bytes ignored
    we0 = we_cnt;
    bus_start(); wr_byte({4'b1010, strap, 1'b0}, ack); wr_byte(8'h14, ack);
    wr_byte(8'h99, ack); bus_stop();
    exp_mem[20] = 8'h99;
    oe0 = oe_cnt;
    scl_m = 1'b0; repeat (2) @(negedge clk);
    wr_byte(8'h77, ack);
    chk("R1 idle after stop ack", int'(ack), 0);
    chk("R1 idle after stop drive", oe_cnt - oe0, 0);
    bus_stop();
    chk("R1 one write only", we_cnt - we0, 1);
    chk("R1 stored", int'(tb_mem[20]), int'(exp_mem[20]));

    // R9: repeated START part-way through a data byte
    we0 = we_cnt;
    bus_start(); wr_byte({4'b1010, strap, 1'b0}, ack); wr_byte(8'h1E, ack);
    for (int i = 0; i < 4; i++) begin logic s; clk_bit(1'b0, s); end
    bus_start(); wr_byte({4'b1010, strap, 1'b1}, ack);
    chk("R9 restart ack", int'(ack), 1);
    rd_byte(1'b0, b); bus_stop();
    chk("R9 restart read", int'(b), int'(exp_mem[30]));
    chk("R9 partial byte not written", we_cnt - we0, 0);

    chk("R10 drive changes only with clock low", viol_cnt, 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule